// File: doc/BRIEF.md
# Serial Port FIFO Trigger Control

This block holds the transmit and receive byte queues of a serial port, the 16-bit control register that governs them, and the two level flags that tell software or a transfer engine when to act. The processor pushes bytes into the transmit queue, and the serial shifter drains them. The shifter fills the receive queue, and the processor drains it. Each queue keeps its own count. A push to a full queue is dropped and recorded in a sticky overrun flag.

The control register holds a receive trigger code, a transmit trigger code, a separate clear bit for each queue and a loop-back enable. The receive trigger code is decoded through one of two tables, chosen by a mode input that selects asynchronous or clocked-synchronous framing. The receive-full flag is high while the receive count is at or above the decoded threshold. The transmit-low flag is high while the transmit count is at or below the decoded level. With loop-back enabled, every byte the shifter takes from the transmit queue goes straight into the receive queue, and the external receive input is ignored.

Top module: `serfifo_trig`

## Requirements
- R1: A write stores `cfg_wdata & 16'h00F7`, and `cfg_rdata` returns the stored value. Bits 15:8 and bit 3 always read 0. The field positions are: receive trigger at 7:6, transmit trigger at 5:4, transmit clear at bit 2, receive clear at bit 1 and loop-back at bit 0.
- R2: While `rst_n` is low, the register reads 0x0000, both counts are 0, both heads are 0, both overrun flags are 0, `rx_full` is 0 and `tx_low` is 1.
- R3: With `sync_mode`=0, receive trigger codes 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14, and `rx_full` = (`rx_count` >= threshold).
- R4: With `sync_mode`=1, receive trigger codes 0, 1, 2 and 3 give thresholds of 1, 2, 8 and 14, under the same rule as R3.
- R5: Transmit trigger codes 0, 1, 2 and 3 give levels of 8, 4, 2 and 0, and `tx_low` = (`tx_count` <= level).
- R6: Each queue is 16 entries of 8 bits and is first in, first out. A push stores a byte and a pop removes the head byte, both in the cycle after the strobe. The count tracks accepted pushes minus accepted pops.
- R7: A push to a queue holding 16 entries is dropped, even when a pop occurs in the same cycle, and it sets that queue's overrun flag. The flag stays set until the queue's clear bit is set.
- R8: The head output reads 0 when its queue is empty, and a pop of an empty queue changes nothing.
- R9: While a queue's clear bit is 1, that queue empties in the next cycle, holds its count at 0, ignores pushes and pops, and clears its overrun flag.
- R10: While the loop-back bit is 1, `rx_push` and `rx_data` are ignored. Each accepted transmit pop pushes that transmit head byte into the receive queue.
- R11: After pops take `rx_count` below the threshold, `rx_full` falls in the same cycle that the count falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 0 asynchronous, 1 clocked-synchronous receive trigger table |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read value |
| tx_push | input | 1 | Processor push to transmit queue |
| tx_data | input | 8 | Byte to push into transmit queue |
| tx_pop | input | 1 | Shifter takes transmit head byte |
| tx_head | output | 8 | Transmit head byte, 0 when empty |
| tx_count | output | 5 | Transmit queue fill count |
| tx_low | output | 1 | Transmit count at or below decoded level |
| tx_overrun | output | 1 | Sticky transmit push-while-full flag |
| rx_push | input | 1 | Shifter push to receive queue |
| rx_data | input | 8 | Byte to push into receive queue |
| rx_pop | input | 1 | Processor read of receive head byte |
| rx_head | output | 8 | Receive head byte, 0 when empty |
| rx_count | output | 5 | Receive queue fill count |
| rx_full | output | 1 | Receive count at or above decoded threshold |
| rx_overrun | output | 1 | Sticky receive push-while-full flag |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge. They also assume that push and pop strobes are sampled once per cycle as single-cycle requests, with no handshake expected back. The stimulus changes inputs only on falling edges and applies no backpressure. It may push into full queues, pop empty ones, toggle `sync_mode` at any time and write arbitrary values, reserved bits included. Clear bits are kept rare in the random writes so that the queues fill far enough to reach the 14-entry threshold and the overrun case.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   localparam int unsigned CFG_W = 16;
   localparam logic [CFG_W-1:0] CFG_WMASK = 16'h00F7;

   typedef enum logic {
      MODE_ASYNC = 1'b0,
      MODE_SYNC  = 1'b1
   } link_mode_e;

   typedef struct packed {
      logic [7:0] unused_hi;
      logic [1:0] rx_trig;
      logic [1:0] tx_trig;
      logic       unused_b3;
      logic       tx_clr;
      logic       rx_clr;
      logic       loop_en;
   } cfg_t;

   function automatic int unsigned rx_threshold(link_mode_e m, logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return (m == MODE_SYNC) ? 2 : 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

   function automatic int unsigned tx_level(logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 4;
         2'd2:    return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/sfc_cfg_reg.sv
module sfc_cfg_reg #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] WMASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   logic [W-1:0] store;

   always_ff @(posedge clk) begin
      if (!rst_n)
         store <= '0;
      else if (wr)
         store <= wdata & WMASK;
   end

   assign q = store;

   // R1: no write, no change
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));

endmodule

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    dout,
   output logic [CNT_W-1:0] count,
   output logic             ovr
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   initial begin
      assert (DEPTH >= 2) else $error("sfc_fifo: DEPTH must be at least 2");
      assert (DW >= 1) else $error("sfc_fifo: DW must be at least 1");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             empty, full, push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_CNT);
   assign push_ok = push & ~full & ~clr;
   assign pop_ok  = pop & ~empty & ~clr;

   generate
      if (POW2) begin : g_wrap_pow2
         always_comb begin
            wr_nxt = wr_ptr + 1'b1;
            rd_nxt = rd_ptr + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok)
         mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovr    <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push && full)
            ovr <= 1'b1;
      end
   end

   assign count = cnt;
   assign dout  = empty ? '0 : mem[rd_ptr];

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && count == FULL_CNT && !pop && !clr) |=> (count == FULL_CNT && ovr));

   assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clr) |=> ovr);

   assert_clr_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !ovr));

   assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> (dout == '0));

   assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !push) |=> (count == '0));

endmodule

// File: rtl/sfc_flags.sv
module sfc_flags
   import sfc_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  link_mode_e       mode,
   input  logic [1:0]       rx_trig,
   input  logic [1:0]       tx_trig,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   output logic             rx_full,
   output logic             tx_low
);

   int unsigned rx_thr, tx_lvl;

   always_comb begin
      rx_thr  = rx_threshold(mode, rx_trig);
      tx_lvl  = tx_level(tx_trig);
      rx_full = (int'(rx_count) >= int'(rx_thr));
      tx_low  = (int'(tx_count) <= int'(tx_lvl));
   end

   // R3: smallest threshold is one entry
   assert_rdf_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> (rx_count != '0));

   // R4: fourteen or more always triggers, in either table
   assert_rdf_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count >= CNT_W'(14)) |-> rx_full);

   assert_txlow_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == '0) |-> tx_low);

endmodule

// File: rtl/serfifo_trig.sv
module serfifo_trig
   import sfc_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_mode,
   input  logic             cfg_wr,
   input  logic [15:0]      cfg_wdata,
   output logic [15:0]      cfg_rdata,
   input  logic             tx_push,
   input  logic [DW-1:0]    tx_data,
   input  logic             tx_pop,
   output logic [DW-1:0]    tx_head,
   output logic [CNT_W-1:0] tx_count,
   output logic             tx_low,
   output logic             tx_overrun,
   input  logic             rx_push,
   input  logic [DW-1:0]    rx_data,
   input  logic             rx_pop,
   output logic [DW-1:0]    rx_head,
   output logic [CNT_W-1:0] rx_count,
   output logic             rx_full,
   output logic             rx_overrun
);

   initial begin
      assert (DEPTH >= 14) else $error("serfifo_trig: DEPTH must hold the largest threshold");
   end

   logic [15:0] cfg_q;
   cfg_t        cfg;
   logic        rx_push_sel, tx_pop_ok;
   logic [DW-1:0] rx_din_sel;

   sfc_cfg_reg #(.W(CFG_W), .WMASK(CFG_WMASK)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .q     (cfg_q)
   );

   assign cfg       = cfg_t'(cfg_q);
   assign cfg_rdata = cfg_q;

   sfc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cfg.tx_clr),
      .push  (tx_push),
      .din   (tx_data),
      .pop   (tx_pop),
      .dout  (tx_head),
      .count (tx_count),
      .ovr   (tx_overrun)
   );

   assign tx_pop_ok   = tx_pop & (tx_count != '0) & ~cfg.tx_clr;
   assign rx_push_sel = cfg.loop_en ? tx_pop_ok : rx_push;
   assign rx_din_sel  = cfg.loop_en ? tx_head   : rx_data;

   sfc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cfg.rx_clr),
      .push  (rx_push_sel),
      .din   (rx_din_sel),
      .pop   (rx_pop),
      .dout  (rx_head),
      .count (rx_count),
      .ovr   (rx_overrun)
   );

   sfc_flags #(.CNT_W(CNT_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (link_mode_e'(sync_mode)),
      .rx_trig  (cfg.rx_trig),
      .tx_trig  (cfg.tx_trig),
      .rx_count (rx_count),
      .tx_count (tx_count),
      .rx_full  (rx_full),
      .tx_low   (tx_low)
   );

   // R10: with loop-back on and nothing to take from transmit, receive cannot grow
   assert_loop_isolate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.loop_en && !cfg.tx_clr && !cfg.rx_clr && tx_count == '0)
         |=> (rx_count <= $past(rx_count)));

   // R10: a looped byte lands in receive when there is room
   assert_loop_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.loop_en && !cfg.tx_clr && !cfg.rx_clr && tx_pop && tx_count != '0
         && !rx_pop && rx_count != CNT_W'(DEPTH)) |=> (rx_count == $past(rx_count) + 1'b1));

endmodule

// File: tb/serfifo_trig_tb.sv
module serfifo_trig_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n, sync_mode, cfg_wr;
   logic [15:0] cfg_wdata, cfg_rdata;
   logic        tx_push, tx_pop, tx_low, tx_overrun;
   logic [7:0]  tx_data, tx_head;
   logic [4:0]  tx_count, rx_count;
   logic        rx_push, rx_pop, rx_full, rx_overrun;
   logic [7:0]  rx_data, rx_head;

   always #(CLK_PERIOD/2) clk = ~clk;

   serfifo_trig u_dut (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_head(tx_head),
      .tx_count(tx_count), .tx_low(tx_low), .tx_overrun(tx_overrun),
      .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop), .rx_head(rx_head),
      .rx_count(rx_count), .rx_full(rx_full), .rx_overrun(rx_overrun)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [15:0] m_cfg;
   logic [7:0]  m_tx[$];
   logic [7:0]  m_rx[$];
   bit          m_txo, m_rxo;
   bit          prev_rdf;

   function automatic int exp_rx_thr(logic m, logic [1:0] c);
      if (c == 2'd0) return 1;
      if (c == 2'd1) return m ? 2 : 4;
      if (c == 2'd2) return 8;
      return 14;
   endfunction

   function automatic int exp_tx_lvl(logic [1:0] c);
      if (c == 2'd0) return 8;
      if (c == 2'd1) return 4;
      if (c == 2'd2) return 2;
      return 0;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic [15:0] c;
      logic [7:0]  thead, rd;
      bit tpop_ok, rpush, full;
      c = m_cfg;
      thead = (m_tx.size() > 0) ? m_tx[0] : 8'd0;
      tpop_ok = 0;
      if (c[2]) begin
         m_tx.delete(); m_txo = 0;
      end else begin
         full = (m_tx.size() == DEPTH);
         if (tx_pop && m_tx.size() > 0) begin
            void'(m_tx.pop_front()); tpop_ok = 1;
         end
         if (tx_push) begin
            if (full) m_txo = 1; else m_tx.push_back(tx_data);
         end
      end
      rpush = c[0] ? tpop_ok : rx_push;
      rd    = c[0] ? thead : rx_data;
      if (c[1]) begin
         m_rx.delete(); m_rxo = 0;
      end else begin
         full = (m_rx.size() == DEPTH);
         if (rx_pop && m_rx.size() > 0) void'(m_rx.pop_front());
         if (rpush) begin
            if (full) m_rxo = 1; else m_rx.push_back(rd);
         end
      end
      if (cfg_wr) m_cfg = cfg_wdata & 16'h00F7;
   endtask

   task automatic compare();
      bit rdf;
      string ctag, rtag;
      rdf  = (int'(m_rx.size()) >= exp_rx_thr(sync_mode, m_cfg[7:6]));
      chk("R1", "cfg_rdata", cfg_rdata, m_cfg);
      ctag = m_cfg[2] ? "R9" : "R6";
      chk(ctag, "tx_count", tx_count, m_tx.size());
      rtag = m_cfg[1] ? "R9" : (m_cfg[0] ? "R10" : "R6");
      chk(rtag, "rx_count", rx_count, m_rx.size());
      if (m_tx.size() == 0) chk("R8", "tx_head", tx_head, 0);
      else                  chk("R6", "tx_head", tx_head, m_tx[0]);
      if (m_rx.size() == 0) chk("R8", "rx_head", rx_head, 0);
      else                  chk(m_cfg[0] ? "R10" : "R6", "rx_head", rx_head, m_rx[0]);
      if (prev_rdf && !rdf) chk("R11", "rx_full", rx_full, rdf);
      else                  chk(sync_mode ? "R4" : "R3", "rx_full", rx_full, rdf);
      chk("R5", "tx_low", tx_low, int'(m_tx.size()) <= exp_tx_lvl(m_cfg[5:4]));
      chk("R7", "tx_overrun", tx_overrun, m_txo);
      chk("R7", "rx_overrun", rx_overrun, m_rxo);
      prev_rdf = rdf;
   endtask

   task automatic cyc(bit wr, logic [15:0] wd, bit tpu, logic [7:0] td, bit tpo,
                      bit rpu, logic [7:0] rdv, bit rpo);
      cfg_wr = wr; cfg_wdata = wd; tx_push = tpu; tx_data = td; tx_pop = tpo;
      rx_push = rpu; rx_data = rdv; rx_pop = rpo;
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 16'h0, 0, 8'h0, 0, 0, 8'h0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; sync_mode = 0; cfg_wr = 0; cfg_wdata = '0;
      tx_push = 0; tx_data = '0; tx_pop = 0; rx_push = 0; rx_data = '0; rx_pop = 0;
      m_cfg = '0; m_txo = 0; m_rxo = 0; prev_rdf = 0;
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2", "cfg_rdata", cfg_rdata, 0);
      chk("R2", "tx_count", tx_count, 0);
      chk("R2", "rx_count", rx_count, 0);
      chk("R2", "rx_full", rx_full, 0);
      chk("R2", "tx_low", tx_low, 1);
      chk("R2", "overrun", {tx_overrun, rx_overrun}, 0);
      chk("R2", "heads", {tx_head, rx_head}, 0);
      rst_n = 1;
      @(negedge clk);
      compare();

      // R1: reserved bits read zero
      cyc(1, 16'hFF08, 0, 0, 0, 0, 0, 0);
      cyc(1, 16'hFFF0, 0, 0, 0, 0, 0, 0);

      // R3: async thresholds, fill receive past full for R7
      for (int code = 0; code < 4; code++) begin
         cyc(1, 16'(code << 6), 0, 0, 0, 0, 0, 0);
         for (int k = 0; k < 17; k++) cyc(0, 0, 0, 0, 0, 1, 8'(k + 16*code), 0);
         // R11: drain and watch rx_full fall
         for (int k = 0; k < 17; k++) cyc(0, 0, 0, 0, 0, 0, 0, 1);
         cyc(1, 16'(code << 6) | 16'h0002, 0, 0, 0, 0, 0, 0);
         cyc(1, 16'(code << 6), 0, 0, 0, 0, 0, 0);
      end
      // R4: sync thresholds
      sync_mode = 1;
      for (int code = 0; code < 4; code++) begin
         cyc(1, 16'(code << 6), 0, 0, 0, 0, 0, 0);
         for (int k = 0; k < 15; k++) cyc(0, 0, 0, 0, 0, 1, 8'(k), 0);
         for (int k = 0; k < 15; k++) cyc(0, 0, 0, 0, 0, 0, 0, 1);
      end
      sync_mode = 0;

      // R5: transmit levels, R7 overrun on transmit with a same-cycle pop
      for (int code = 0; code < 4; code++) begin
         cyc(1, 16'(code << 4), 0, 0, 0, 0, 0, 0);
         for (int k = 0; k < 16; k++) cyc(0, 0, 1, 8'(8'hA0 + k), 0, 0, 0, 0);
         cyc(0, 0, 1, 8'h55, 1, 0, 0, 0);
         for (int k = 0; k < 17; k++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
         cyc(1, 16'h0004, 0, 0, 0, 0, 0, 0);
      end

      // R9: clear bits held while pushing
      cyc(1, 16'h0006, 1, 8'h11, 0, 1, 8'h22, 0);
      for (int k = 0; k < 4; k++) cyc(0, 0, 1, 8'h33, 1, 1, 8'h44, 1);
      cyc(1, 16'h0000, 0, 0, 0, 0, 0, 0);

      // R10: loop-back moves bytes, external receive ignored
      for (int k = 0; k < 6; k++) cyc(0, 0, 1, 8'(8'hC0 + k), 0, 0, 0, 0);
      cyc(1, 16'h0001, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 1, 1, 8'hEE, 0);
      for (int k = 0; k < 7; k++) cyc(0, 0, 0, 0, 0, 0, 0, 1);
      cyc(1, 16'h0000, 0, 0, 0, 0, 0, 0);

      // random phase
      for (int n = 0; n < 6000; n++) begin
         bit wr;
         logic [15:0] wd;
         wr = ($urandom % 32) == 0;
         wd = 16'($urandom);
         if (($urandom % 6) != 0) wd[2:1] = 2'b00;
         if (($urandom % 100) == 0) sync_mode = ~sync_mode;
         cyc(wr, wd, ($urandom % 3) != 0, 8'($urandom), ($urandom % 3) == 0,
             ($urandom % 2) == 0, 8'($urandom), ($urandom % 3) == 0);
      end
      idle(2);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule